// File: doc/BRIEF.md
# NAND Address-Encoded Command Sequencer

This block sits between a simple 32-bit host port and an 8-bit raw NAND flash bus. The host does not program any command registers. Each access carries its sequencing instructions in the address bits, and the block turns that single access into a run of flash bus cycles. These are command-latch cycles, address-latch cycles, and data cycles with fixed strobe timing.

A command-phase write names a first command byte, an optional closing command byte and an address-cycle count. The address bytes themselves travel in the write data. A data-phase access moves one to four bytes over the flash bus. It can also fire the stored closing command afterwards and release chip enable. The host stalls on a wait signal until every flash cycle of the access is over.

A separate control location reports a sticky flag. The flag is set by a rising edge on the flash ready/busy line, and the host clears it by writing to that location.

Top module: `nand_addr_seq`

## Requirements
- R1: After reset, chip enable, write strobe and read strobe are high (inactive), command latch and address latch are low, `h_wait` is low while no request is present, and the ready flag reads 0.
- R2: A write with address bit 19 = 0 (command phase) issues a command-latch cycle carrying address bits [10:3]. It then issues N address-latch cycles, where N is address bits [23:21] and N ≤ 4, taking bytes from `h_wdata` lowest byte first. If address bit 20 is set, it finally issues a command-latch cycle carrying address bits [18:11].
- R3: When N > 4, the first command-phase write sends four address bytes and no closing command. The next command-phase write sends the remaining N-4 bytes from its lowest data bytes, with its own address fields ignored, and then sends the stored closing command if bit 20 of the first write was set.
- R4: Every write-type flash cycle (command, address, data out) lasts 5 clocks. The write strobe is low for the first 3 clocks. Latch lines and output data stay constant through the cycle, and consecutive cycles follow back to back.
- R5: Every read cycle lasts 5 clocks with the read strobe low for the first 3 clocks. The flash byte is captured at the end of the third low clock, so data only needs to be valid 2 clocks after the strobe falls.
- R6: A write with address bit 19 = 1 (data phase) issues one data-out cycle per enabled byte lane, in ascending lane order, carrying that lane of `h_wdata`.
- R7: A data-phase read issues one read cycle per enabled lane in ascending order and returns each byte in its own lane of `h_rdata`. Disabled lanes read 0.
- R8: In a data phase, address bit 20 appends a command-latch cycle with the stored closing command after the data cycles. Address bit 21 releases chip enable once the access finishes.
- R9: Chip enable goes low at the first flash cycle of any access and stays low across later accesses until a data phase with bit 21 completes.
- R10: `h_wait` stays high while a request is pending and drops two clocks after the final flash cycle of the access ends; `h_rdata` is valid in that cycle.
- R11: With address bit 24 set, a read returns the ready flag in bit 0. A rising edge on `nd_rb_n` sets the flag, and a write there with data bit 0 set clears it.
- R12: A command-phase read produces no flash cycles, leaves chip enable unchanged and returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_req | input | 1 | Host access request, held until `h_wait` is low |
| h_we | input | 1 | 1 = write, 0 = read |
| h_addr | input | 22 | Host address bits [24:3] carrying the control fields |
| h_wdata | input | 32 | Host write data |
| h_be | input | 4 | Byte lane enables for data phases |
| h_rdata | output | 32 | Host read data |
| h_wait | output | 1 | Stall until the access completes |
| nd_ce_n | output | 1 | Flash chip enable, active low |
| nd_cle | output | 1 | Command latch enable |
| nd_ale | output | 1 | Address latch enable |
| nd_we_n | output | 1 | Write strobe, active low |
| nd_re_n | output | 1 | Read strobe, active low |
| nd_dq_o | output | 8 | Flash data out |
| nd_dq_oe | output | 1 | Flash data output enable |
| nd_dq_i | input | 8 | Flash data in |
| nd_rb_n | input | 1 | Flash ready/busy, low = busy |

## Verification
The assertions check, on every clock, the rules that hold cycle by cycle. Command and address latch are never both high, and the read and write strobes never overlap. Data is driven and stable while the write strobe is low, and chip enable covers every strobe. The engine is only busy while the sequencer is in a transfer state, and a rising ready line sets the flag.

Byte order, the split of long address runs across two writes, the deferred closing command, lane packing on reads, chip-enable release and the exact stall length are only visible in the scenarios. The bench's flash model and event queues compare those scenarios against expected cycle lists.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [1:0] {
    CYC_CMD = 2'd0,
    CYC_ADR = 2'd1,
    CYC_WR  = 2'd2,
    CYC_RD  = 2'd3
  } cyc_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CMD1  = 3'd1,
    ST_ADDR  = 3'd2,
    ST_CMD2  = 3'd3,
    ST_DATA  = 3'd4,
    ST_DRAIN = 3'd5,
    ST_RESP  = 3'd6
  } seq_state_e;

  // address field positions (decoded by the sequencer)
  localparam int A_CMD1_LO = 3;
  localparam int A_CMD2_LO = 11;
  localparam int A_PHASE   = 19;
  localparam int A_ENDV    = 20;
  localparam int A_NCYC_LO = 21;
  localparam int A_CLRCS   = 21;
  localparam int A_CTRL    = 24;

endpackage

// File: rtl/nand_cyc_engine.sv
module nand_cyc_engine
  import nand_seq_pkg::*;
#(
  parameter int unsigned T_WP  = 3,
  parameter int unsigned T_WC  = 5,
  parameter int unsigned T_RP  = 3,
  parameter int unsigned T_RC  = 5,
  parameter int unsigned T_REA = 2
) (
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       go,
  input  cyc_kind_e  kind_i,
  input  logic [7:0] byte_i,
  input  logic [1:0] lane_i,
  output logic       free,
  output logic       busy,
  output logic       cle,
  output logic       ale,
  output logic       we_n,
  output logic       re_n,
  output logic [7:0] dq_o,
  output logic       dq_oe,
  input  logic [7:0] dq_i,
  output logic       cap_vld,
  output logic [1:0] cap_lane,
  output logic [7:0] cap_byte
);

  localparam int unsigned TMAX = (T_WC > T_RC) ? T_WC : T_RC;
  localparam int unsigned CW   = (TMAX > 2) ? $clog2(TMAX) : 1;
  localparam logic [CW-1:0] WP_C  = CW'(T_WP);
  localparam logic [CW-1:0] RP_C  = CW'(T_RP);
  localparam logic [CW-1:0] REA_C = CW'(T_REA);
  localparam logic [CW-1:0] WC_L  = CW'(T_WC - 1);
  localparam logic [CW-1:0] RC_L  = CW'(T_RC - 1);

  logic            busy_q, busy_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  cyc_kind_e       kind_q, kind_d;
  logic [7:0]      byte_q, byte_d;
  logic [1:0]      lane_q, lane_d;
  logic            cle_q, ale_q, we_n_q, re_n_q, oe_q;
  logic            cle_d, ale_d, we_n_d, re_n_d, oe_d;
  logic [7:0]      dq_q;
  logic            last, rd_q, wr_d, rd_d;

  assign rd_q = busy_q && (kind_q == CYC_RD);
  assign last = busy_q && (cnt_q == (rd_q ? RC_L : WC_L));
  assign free = !busy_q || last;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    kind_d = kind_q;
    byte_d = byte_q;
    lane_d = lane_q;
    if (go && free) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      kind_d = kind_i;
      byte_d = byte_i;
      lane_d = lane_i;
    end else if (last) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d  = cnt_q + 1'b1;
    end
    wr_d   = busy_d && (kind_d != CYC_RD);
    rd_d   = busy_d && (kind_d == CYC_RD);
    cle_d  = busy_d && (kind_d == CYC_CMD);
    ale_d  = busy_d && (kind_d == CYC_ADR);
    we_n_d = !(wr_d && (cnt_d < WP_C));
    re_n_d = !(rd_d && (cnt_d < RP_C));
    oe_d   = wr_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      kind_q <= CYC_CMD;
      byte_q <= '0;
      lane_q <= '0;
      cle_q  <= 1'b0;
      ale_q  <= 1'b0;
      we_n_q <= 1'b1;
      re_n_q <= 1'b1;
      oe_q   <= 1'b0;
      dq_q   <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      kind_q <= kind_d;
      byte_q <= byte_d;
      lane_q <= lane_d;
      cle_q  <= cle_d;
      ale_q  <= ale_d;
      we_n_q <= we_n_d;
      re_n_q <= re_n_d;
      oe_q   <= oe_d;
      dq_q   <= byte_d;
    end
  end

  assign busy     = busy_q;
  assign cle      = cle_q;
  assign ale      = ale_q;
  assign we_n     = we_n_q;
  assign re_n     = re_n_q;
  assign dq_oe    = oe_q;
  assign dq_o     = dq_q;
  assign cap_vld  = rd_q && (cnt_q == REA_C);
  assign cap_lane = lane_q;
  assign cap_byte = dq_i;

  // R2: command and address latch are exclusive
  p_latch_excl_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    !(cle_q && ale_q));
  // R4/R5: read and write strobes never overlap
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    !(!we_n_q && !re_n_q));
  // R4: data driven whenever the write strobe is low
  p_we_data_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    !we_n_q |-> oe_q);
  // R4: data stable during a write strobe low phase
  p_dq_hold_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (!we_n_q && !$past(we_n_q)) |-> $stable(dq_q));

endmodule

// File: rtl/nand_rb_flag.sv
module nand_rb_flag (
  input  logic clk,
  input  logic rst_ni,
  input  logic rb_n,
  input  logic clr,
  output logic flag,
  output logic level
);

  logic s1_q, s2_q, prev_q, flag_q, flag_d, rise;

  assign rise = s2_q && !prev_q;

  always_comb begin
    flag_d = flag_q;
    if (rise)     flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      s1_q   <= rb_n;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      flag_q <= flag_d;
    end
  end

  assign flag  = flag_q;
  assign level = s2_q;

  // R11: a synchronized rising ready line sets the flag
  p_rise_sets_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    (s2_q && !prev_q) |=> flag_q);

endmodule

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_ni,
  input  logic        h_req,
  input  logic        h_we,
  input  logic [24:3] h_addr,
  input  logic [31:0] h_wdata,
  input  logic [3:0]  h_be,
  output logic [31:0] h_rdata,
  output logic        h_wait,
  output logic        item_vld,
  output cyc_kind_e   item_kind,
  output logic [7:0]  item_byte,
  output logic [1:0]  item_lane,
  input  logic        eng_free,
  input  logic        eng_busy,
  input  logic        cap_vld,
  input  logic [1:0]  cap_lane,
  input  logic [7:0]  cap_byte,
  output logic        ce_n,
  output logic        flag_clr,
  input  logic        flag_val,
  input  logic        rb_lvl
);

  seq_state_e  st_q, st_d;
  logic [7:0]  start_q, start_d, end_q, end_d;
  logic        endv_q, endv_d;
  logic [2:0]  pend_q, pend_d, left_q, left_d;
  logic [1:0]  idx_q, idx_d;
  logic [31:0] wdata_q, wdata_d, rdata_q, rdata_d;
  logic [3:0]  lanes_q, lanes_d;
  logic        dwr_q, dwr_d, tail_q, tail_d, clrcs_q, clrcs_d, ce_q, ce_d;
  logic [2:0]  ncyc;
  logic [1:0]  low_lane;
  logic        acc;

  assign ncyc = h_addr[A_NCYC_LO+2:A_NCYC_LO];

  always_comb begin
    low_lane = 2'd0;
    for (int i = 3; i >= 0; i--) begin
      if (lanes_q[i]) low_lane = 2'(i);
    end
  end

  always_comb begin
    st_d = st_q; start_d = start_q; end_d = end_q; endv_d = endv_q;
    pend_d = pend_q; left_d = left_q; idx_d = idx_q; wdata_d = wdata_q;
    rdata_d = rdata_q; lanes_d = lanes_q; dwr_d = dwr_q; tail_d = tail_q;
    clrcs_d = clrcs_q; ce_d = ce_q;
    item_vld = 1'b0; item_kind = CYC_CMD; item_byte = 8'h00; item_lane = 2'd0;
    flag_clr = 1'b0;
    acc = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (h_req) begin
          if (h_addr[A_CTRL]) begin
            rdata_d  = {30'd0, rb_lvl, flag_val};
            flag_clr = h_we && h_wdata[0];
            st_d     = ST_RESP;
          end else if (!h_addr[A_PHASE]) begin
            if (!h_we) begin
              rdata_d = 32'd0;
              st_d    = ST_RESP;
            end else begin
              ce_d    = 1'b1;
              wdata_d = h_wdata;
              idx_d   = 2'd0;
              clrcs_d = 1'b0;
              if (pend_q != 3'd0) begin
                left_d = pend_q;
                pend_d = 3'd0;
                st_d   = ST_ADDR;
              end else begin
                start_d = h_addr[A_CMD1_LO+7:A_CMD1_LO];
                end_d   = h_addr[A_CMD2_LO+7:A_CMD2_LO];
                endv_d  = h_addr[A_ENDV];
                if (ncyc > 3'd4) begin
                  left_d = 3'd4;
                  pend_d = ncyc - 3'd4;
                end else begin
                  left_d = ncyc;
                  pend_d = 3'd0;
                end
                st_d = ST_CMD1;
              end
            end
          end else begin
            ce_d    = 1'b1;
            wdata_d = h_wdata;
            lanes_d = h_be;
            dwr_d   = h_we;
            tail_d  = h_addr[A_ENDV];
            clrcs_d = h_addr[A_CLRCS];
            rdata_d = 32'd0;
            st_d    = ST_DATA;
          end
        end
      end
      ST_CMD1: begin
        item_vld  = 1'b1;
        item_kind = CYC_CMD;
        item_byte = start_q;
        acc       = eng_free;
        if (acc) begin
          if (left_q != 3'd0) st_d = ST_ADDR;
          else if (endv_q)    st_d = ST_CMD2;
          else                st_d = ST_DRAIN;
        end
      end
      ST_ADDR: begin
        item_vld  = 1'b1;
        item_kind = CYC_ADR;
        item_byte = wdata_q[{idx_q, 3'b000} +: 8];
        acc       = eng_free;
        if (acc) begin
          idx_d  = idx_q + 2'd1;
          left_d = left_q - 3'd1;
          if (left_q == 3'd1)
            st_d = (pend_q == 3'd0 && endv_q) ? ST_CMD2 : ST_DRAIN;
        end
      end
      ST_CMD2: begin
        item_vld  = 1'b1;
        item_kind = CYC_CMD;
        item_byte = end_q;
        acc       = eng_free;
        if (acc) st_d = ST_DRAIN;
      end
      ST_DATA: begin
        if (lanes_q == 4'd0) begin
          st_d = tail_q ? ST_CMD2 : ST_DRAIN;
        end else begin
          item_vld  = 1'b1;
          item_kind = dwr_q ? CYC_WR : CYC_RD;
          item_byte = wdata_q[{low_lane, 3'b000} +: 8];
          item_lane = low_lane;
          acc       = eng_free;
          if (acc) lanes_d[low_lane] = 1'b0;
        end
      end
      ST_DRAIN: begin
        if (!eng_busy) begin
          st_d = ST_RESP;
          if (clrcs_q) ce_d = 1'b0;
        end
      end
      ST_RESP:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
    if (cap_vld) rdata_d[{cap_lane, 3'b000} +: 8] = cap_byte;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; start_q <= '0; end_q <= '0; endv_q <= 1'b0;
      pend_q <= '0; left_q <= '0; idx_q <= '0; wdata_q <= '0; rdata_q <= '0;
      lanes_q <= '0; dwr_q <= 1'b0; tail_q <= 1'b0; clrcs_q <= 1'b0; ce_q <= 1'b0;
    end else begin
      st_q <= st_d; start_q <= start_d; end_q <= end_d; endv_q <= endv_d;
      pend_q <= pend_d; left_q <= left_d; idx_q <= idx_d; wdata_q <= wdata_d;
      rdata_q <= rdata_d; lanes_q <= lanes_d; dwr_q <= dwr_d; tail_q <= tail_d;
      clrcs_q <= clrcs_d; ce_q <= ce_d;
    end
  end

  assign h_wait  = h_req && (st_q != ST_RESP);
  assign h_rdata = rdata_q;
  assign ce_n    = !ce_q;

  // R3: leftover address bytes never exceed what one extra write carries
  p_pend_bound_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    pend_q <= 3'd3);
  // R10: the engine only runs while an access is still outstanding
  p_busy_in_access_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    eng_busy |-> (st_q != ST_IDLE && st_q != ST_RESP));

endmodule

// File: rtl/nand_addr_seq.sv
module nand_addr_seq
  import nand_seq_pkg::*;
#(
  parameter int unsigned T_WP  = 3,
  parameter int unsigned T_WC  = 5,
  parameter int unsigned T_RP  = 3,
  parameter int unsigned T_RC  = 5,
  parameter int unsigned T_REA = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        h_req,
  input  logic        h_we,
  input  logic [24:3] h_addr,
  input  logic [31:0] h_wdata,
  input  logic [3:0]  h_be,
  output logic [31:0] h_rdata,
  output logic        h_wait,
  output logic        nd_ce_n,
  output logic        nd_cle,
  output logic        nd_ale,
  output logic        nd_we_n,
  output logic        nd_re_n,
  output logic [7:0]  nd_dq_o,
  output logic        nd_dq_oe,
  input  logic [7:0]  nd_dq_i,
  input  logic        nd_rb_n
);

  logic       rs1_q, rs2_q, rst_ni;
  logic       item_vld, eng_free, eng_busy, cap_vld, flag_clr, flag_val, rb_lvl;
  cyc_kind_e  item_kind;
  logic [7:0] item_byte, cap_byte;
  logic [1:0] item_lane, cap_lane;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_ni = rs2_q;

  nand_seq_ctrl u_ctrl (
    .clk(clk), .rst_ni(rst_ni),
    .h_req(h_req), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata), .h_be(h_be),
    .h_rdata(h_rdata), .h_wait(h_wait),
    .item_vld(item_vld), .item_kind(item_kind), .item_byte(item_byte), .item_lane(item_lane),
    .eng_free(eng_free), .eng_busy(eng_busy),
    .cap_vld(cap_vld), .cap_lane(cap_lane), .cap_byte(cap_byte),
    .ce_n(nd_ce_n), .flag_clr(flag_clr), .flag_val(flag_val), .rb_lvl(rb_lvl)
  );

  nand_cyc_engine #(
    .T_WP(T_WP), .T_WC(T_WC), .T_RP(T_RP), .T_RC(T_RC), .T_REA(T_REA)
  ) u_eng (
    .clk(clk), .rst_ni(rst_ni),
    .go(item_vld), .kind_i(item_kind), .byte_i(item_byte), .lane_i(item_lane),
    .free(eng_free), .busy(eng_busy),
    .cle(nd_cle), .ale(nd_ale), .we_n(nd_we_n), .re_n(nd_re_n),
    .dq_o(nd_dq_o), .dq_oe(nd_dq_oe), .dq_i(nd_dq_i),
    .cap_vld(cap_vld), .cap_lane(cap_lane), .cap_byte(cap_byte)
  );

  nand_rb_flag u_flag (
    .clk(clk), .rst_ni(rst_ni), .rb_n(nd_rb_n), .clr(flag_clr),
    .flag(flag_val), .level(rb_lvl)
  );

  // R9: chip enable covers every latch or strobe activity
  p_ce_cover_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (nd_cle || nd_ale || !nd_we_n || !nd_re_n) |-> !nd_ce_n);

endmodule

// File: tb/nand_addr_seq_tb.sv
module nand_addr_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int T_WP = 3;
  localparam int T_RP = 3;

  logic        clk, rst_n, h_req, h_we, h_wait, nd_ce_n, nd_cle, nd_ale;
  logic        nd_we_n, nd_re_n, nd_dq_oe, nd_rb_n;
  logic [24:3] h_addr;
  logic [31:0] h_wdata, h_rdata;
  logic [3:0]  h_be;
  logic [7:0]  nd_dq_o, nd_dq_i;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int obs_q[$];
  int exp_q[$];
  int rdsrc_q[$];
  int wlow = 0;
  int rlow = 0;
  logic prev_we = 1'b1;
  logic prev_re = 1'b1;

  nand_addr_seq u_dut (
    .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_we(h_we), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_be(h_be), .h_rdata(h_rdata), .h_wait(h_wait),
    .nd_ce_n(nd_ce_n), .nd_cle(nd_cle), .nd_ale(nd_ale), .nd_we_n(nd_we_n),
    .nd_re_n(nd_re_n), .nd_dq_o(nd_dq_o), .nd_dq_oe(nd_dq_oe),
    .nd_dq_i(nd_dq_i), .nd_rb_n(nd_rb_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic ck(input bit ok, input string req, input logic [31:0] act,
                    input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // flash model and bus monitor, all on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (!nd_we_n) wlow++;
      if (!nd_re_n) rlow++; else rlow = 0;
      if (prev_we == 1'b0 && nd_we_n == 1'b1) begin
        // R4: strobe low time
        ck(wlow == T_WP, "R4 we low clocks", wlow, T_WP);
        obs_q.push_back(((nd_cle ? 0 : nd_ale ? 1 : 2) << 8) | int'(nd_dq_o));
        wlow = 0;
      end
      if (prev_re == 1'b0 && nd_re_n == 1'b1) begin
        if (rdsrc_q.size() > 0) begin
          obs_q.push_back((3 << 8) | rdsrc_q[0]);
          void'(rdsrc_q.pop_front());
        end
      end
      if (!nd_re_n && rdsrc_q.size() > 0)
        nd_dq_i = (rlow >= 3) ? 8'(rdsrc_q[0]) : 8'hA5;   // R5: valid 2 clocks after fall
      else
        nd_dq_i = 8'hA5;
      prev_we = nd_we_n;
      prev_re = nd_re_n;
    end
  end

  task automatic ex(input int kind, input int b);
    exp_q.push_back((kind << 8) | b);
  endtask

  task automatic cmp_ev(input string req);
    ck(obs_q.size() == exp_q.size(), {req, " cycle count"}, obs_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < obs_q.size(); i++)
      ck(obs_q[i] == exp_q[i], {req, " cycle"}, obs_q[i], exp_q[i]);
    obs_q.delete();
    exp_q.delete();
  endtask

  task automatic acc(input bit we, input logic [24:0] a, input logic [31:0] d,
                     input logic [3:0] be, output logic [31:0] rd, output int waits);
    @(negedge clk);
    h_req = 1'b1; h_we = we; h_addr = a[24:3]; h_wdata = d; h_be = be;
    waits = 0;
    forever begin
      @(negedge clk);
      if (!h_wait) break;
      waits++;
    end
    rd = h_rdata;
    h_req = 1'b0;
  endtask

  function automatic logic [24:0] cmd_a(input int s, input int e, input bit v, input int n);
    return 25'((n << 21) | (int'(v) << 20) | (e << 11) | (s << 3));
  endfunction
  function automatic logic [24:0] dat_a(input bit tail, input bit clr);
    return 25'((1 << 19) | (int'(clr) << 21) | (int'(tail) << 20));
  endfunction
  localparam logic [24:0] CTRL_A = 25'(1 << 24);

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog R10: actual %0d expected below %0d", cyc, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int w;
    rst_n = 1'b0; h_req = 1'b0; h_we = 1'b0; h_addr = '0; h_wdata = '0; h_be = '0;
    nd_rb_n = 1'b1; nd_dq_i = 8'hA5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    ck(nd_ce_n == 1'b1, "R1 ce_n", nd_ce_n, 1);
    ck(nd_we_n == 1'b1 && nd_re_n == 1'b1, "R1 strobes", {nd_we_n, nd_re_n}, 2'b11);
    ck(nd_cle == 1'b0 && nd_ale == 1'b0, "R1 latches", {nd_cle, nd_ale}, 0);
    ck(h_wait == 1'b0, "R1 wait", h_wait, 0);
    acc(1'b0, CTRL_A, 0, 4'hF, rd, w);
    ck(rd[0] == 1'b0, "R1 ready flag", rd[0], 0);

    // R2 single address byte, no closing command
    acc(1'b1, cmd_a(8'h90, 8'h00, 1'b0, 1), 32'h0000_0020, 4'hF, rd, w);
    ex(0, 8'h90); ex(1, 8'h20);
    cmp_ev("R2 id");
    // R9 chip enable stays low after the access
    ck(nd_ce_n == 1'b0, "R9 ce held", nd_ce_n, 0);

    // R2 three bytes with closing command; R10 stall length
    acc(1'b1, cmd_a(8'h60, 8'hD0, 1'b1, 3), 32'h0003_0201, 4'hF, rd, w);
    ex(0, 8'h60); ex(1, 8'h01); ex(1, 8'h02); ex(1, 8'h03); ex(0, 8'hD0);
    cmp_ev("R2 erase");
    ck(w == 5 * 5 + 2, "R10 wait clocks", w, 27);

    // R3 five address cycles split across two writes
    acc(1'b1, cmd_a(8'h00, 8'h30, 1'b1, 5), 32'h4433_2211, 4'hF, rd, w);
    ex(0, 8'h00); ex(1, 8'h11); ex(1, 8'h22); ex(1, 8'h33); ex(1, 8'h44);
    cmp_ev("R3 first write");
    acc(1'b1, cmd_a(8'hFF, 8'hEE, 1'b0, 0), 32'h9988_7755, 4'hF, rd, w);
    ex(1, 8'h55); ex(0, 8'h30);
    cmp_ev("R3 second write");

    // R7 full read with R8 closing command after data
    rdsrc_q = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
    acc(1'b0, dat_a(1'b1, 1'b0), 0, 4'hF, rd, w);
    ex(3, 8'hA1); ex(3, 8'hB2); ex(3, 8'hC3); ex(3, 8'hD4); ex(0, 8'h30);
    cmp_ev("R8 read tail");
    ck(rd == 32'hD4C3_B2A1, "R7 read data R5 capture", rd, 32'hD4C3_B2A1);

    // R6 sparse write lanes
    acc(1'b1, dat_a(1'b0, 1'b0), 32'hDDCC_BBAA, 4'b1010, rd, w);
    ex(2, 8'hBB); ex(2, 8'hDD);
    cmp_ev("R6 lanes");

    // R7 single lane read
    rdsrc_q = '{8'h5C};
    acc(1'b0, dat_a(1'b0, 1'b0), 0, 4'b0100, rd, w);
    ex(3, 8'h5C);
    cmp_ev("R7 one lane");
    ck(rd == 32'h005C_0000, "R7 lane placement", rd, 32'h005C_0000);
    ck(nd_ce_n == 1'b0, "R9 ce across phases", nd_ce_n, 0);

    // R8 release chip enable
    acc(1'b1, dat_a(1'b0, 1'b1), 32'h0000_00E7, 4'b0001, rd, w);
    ex(2, 8'hE7);
    cmp_ev("R8 clear cs");
    ck(nd_ce_n == 1'b1, "R8 ce released", nd_ce_n, 1);

    // R12 command-phase read does nothing
    acc(1'b0, cmd_a(8'h70, 8'h00, 1'b0, 2), 32'h1234_5678, 4'hF, rd, w);
    cmp_ev("R12 no cycles");
    ck(rd == 32'd0, "R12 read value", rd, 0);
    ck(nd_ce_n == 1'b1, "R12 ce unchanged", nd_ce_n, 1);

    // R11 ready flag set and clear
    @(negedge clk); nd_rb_n = 1'b0;
    repeat (4) @(negedge clk); nd_rb_n = 1'b1;
    repeat (5) @(negedge clk);
    acc(1'b0, CTRL_A, 0, 4'hF, rd, w);
    ck(rd[0] == 1'b1, "R11 flag set", rd[0], 1);
    acc(1'b1, CTRL_A, 32'h1, 4'hF, rd, w);
    acc(1'b0, CTRL_A, 0, 4'hF, rd, w);
    ck(rd[0] == 1'b0, "R11 flag cleared", rd[0], 0);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule